// File: doc/BRIEF.md
# Fractional-N Synthesizer Configuration Controller

This block converts a requested sampling-clock frequency, given as an unsigned integer number of hertz, into divider settings for an external fractional-N frequency synthesizer. The synthesizer's feedback loop is closed ahead of its output divider, and its phase detector runs at the 10 MHz reference. The controller first picks a power-of-two output divider from 1 to 64 so that the oscillator lands in its 2.2 to 4.4 GHz range. It then divides the oscillator frequency by the phase-detector frequency to get the integer and fractional parts of the feedback ratio against a fixed modulus of 4095.

The fractional word is rounded up by one step, so the synthesized clock is never below the request. The controller shifts six 32-bit register words out over a three-wire serial link, from the highest register address to the lowest. It also reports the frequency that will actually be produced, so that downstream logic can correct the sample rate.

After reset it writes a fixed initial configuration once. After that it runs a new update only when the request differs from the last value it configured. A busy level and a done pulse frame each update.

Top module: `fracn_cfg_ctrl`

## Requirements
- R1: After reset, `busy` rises and six register words are shifted out, with addresses 5,4,3,2,1,0 in bits [2:0]. Each word is sent most significant bit first, with data valid at the rising edge of `spi_clk`. Each word is followed by one `spi_le` pulse while `spi_clk` is low, after exactly 32 clock rises. `done` and the result outputs are zero out of reset.
- R2: The initial words carry INT = 220 and FRAC = 0 in the address-0 word, and output-divider code 0 in the address-4 word. In every update, the address-1 word carries the modulus 4095 in bits [14:3].
- R3: `div_sel` is the smallest k in 0..6 with request × 2^k ≥ 2.2e9. A request too low for any k uses k = 6.
- R4: `int_val` = floor(request × 2^k / 10e6).
- R5: `frac_val` = floor(remainder × 4095 / 10e6) + 1, where remainder is the part of request × 2^k left over from R4. It is never zero.
- R6: `act_freq` = floor((INT × 4095 + FRAC) × 10e6 / (4095 × 2^k)). It is never below the request.
- R7: A request equal to the last configured value starts no update: `busy` stays low, no serial traffic occurs and the outputs hold.
- R8: `busy` is high from the cycle after a new request is seen until the update completes. `done` is a one-cycle pulse, in the same cycle that `busy` falls and the outputs take their new values.
- R9: The address-0 word holds INT in bits [30:15] and FRAC in bits [14:3]. The address-4 word holds k in bits [22:20] and a 1 in bit 23 (feedback taken ahead of the output divider).
- R10: A request that changes while an update is running is not lost. When the running update completes, a second update for the newest value follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_freq | input | 32 | Requested output frequency in Hz |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle completion pulse |
| int_val | output | 16 | Integer feedback divide value |
| frac_val | output | 12 | Fractional feedback word |
| div_sel | output | 3 | Output divider exponent k (divider 2^k) |
| act_freq | output | 33 | Frequency actually produced, Hz |
| spi_clk | output | 1 | Serial clock |
| spi_data | output | 1 | Serial data |
| spi_le | output | 1 | Load-enable pulse after each word |

## Verification
The request set falls on every output-divider band, including the exact 2.2 GHz boundary and a frequency below the lowest band. The boundary case separates a greater-or-equal comparison from a strict one, and the low case exercises the clamp to 64. Requests with a zero remainder show that FRAC is still bumped to 1. A request with an odd remainder checks the rounding and the reported frequency against the request. A held request and a request changed mid-update tell apart change detection, spurious reconfiguration and lost updates. The captured serial words confirm the field positions and the write order.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
    localparam int FREQ_W   = 32;
    localparam int INT_W    = 16;
    localparam int FRAC_W   = 12;
    localparam int DSEL_W   = 3;
    localparam int DSEL_MAX = 6;
    localparam int WORD_W   = 32;
    localparam int NREG     = 6;
    localparam int DIV_W    = 48;
    localparam int VCO_W    = FREQ_W + DSEL_MAX + 2;
    localparam int PFD_HZ   = 10_000_000;
    localparam int MOD_VAL  = 4095;
    localparam logic [VCO_W-1:0] VCO_MIN = VCO_W'(64'd2_200_000_000);
    localparam logic [WORD_W-1:0] R2_FIX = 32'h0000_4E42;
    localparam logic [WORD_W-1:0] R3_FIX = 32'h0000_04B3;
    localparam logic [WORD_W-1:0] R5_FIX = 32'h0058_0005;

    typedef enum logic [2:0] {
        ST_INIT, ST_INITW, ST_IDLE, ST_QINT, ST_QFRAC, ST_QACT, ST_SEND
    } ctl_st_t;

    typedef struct packed {
        logic [INT_W-1:0]  ival;
        logic [FRAC_W-1:0] fval;
        logic [DSEL_W-1:0] dsel;
    } cfg_t;

    localparam cfg_t INIT_CFG = '{ival: 16'd220, fval: 12'd0, dsel: 3'd0};

    function automatic logic [DSEL_W-1:0] pick_dsel(input logic [FREQ_W-1:0] f);
        logic [DSEL_W-1:0] d;
        d = DSEL_W'(DSEL_MAX);
        for (int k = DSEL_MAX; k >= 0; k--) begin
            if ((VCO_W'(f) << k) >= VCO_MIN) d = DSEL_W'(k);
        end
        return d;
    endfunction

    function automatic logic [NREG*WORD_W-1:0] build_words(input cfg_t c);
        logic [NREG*WORD_W-1:0] w;
        w[0*WORD_W +: WORD_W] = {1'b0, c.ival, c.fval, 3'd0};
        w[1*WORD_W +: WORD_W] = {17'd0, FRAC_W'(MOD_VAL), 3'd1};
        w[2*WORD_W +: WORD_W] = R2_FIX;
        w[3*WORD_W +: WORD_W] = R3_FIX;
        w[4*WORD_W +: WORD_W] = {8'd0, 1'b1, c.dsel, 17'd0, 3'd4};
        w[5*WORD_W +: WORD_W] = R5_FIX;
        return w;
    endfunction
endpackage

// File: rtl/fcc_seqdiv.sv
module fcc_seqdiv #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem,
    output logic         done
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  q, r, bq;
    logic [CW-1:0] cnt;
    logic          run;
    logic [W:0]    trial;

    assign trial = {r, q[W-1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0; r <= '0; bq <= '0; cnt <= '0; run <= 1'b0; done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                q <= dividend; r <= '0; bq <= divisor;
                cnt <= CW'(W); run <= 1'b1;
            end else if (run) begin
                if (trial >= {1'b0, bq}) begin
                    r <= W'(trial - {1'b0, bq});
                    q <= {q[W-2:0], 1'b1};
                end else begin
                    r <= trial[W-1:0];
                    q <= {q[W-2:0], 1'b0};
                end
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quot = q;
    assign rem  = r;

    p_rem_below_divisor_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> (r < bq));
endmodule

// File: rtl/fcc_serial.sv
module fcc_serial #(
    parameter int NW = 6,
    parameter int WW = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [NW*WW-1:0] words,
    output logic           sclk,
    output logic           sdata,
    output logic           le,
    output logic           done
);
    localparam int IW = $clog2(NW + 1);
    localparam int BW = $clog2(WW);

    typedef enum logic [1:0] {SI_IDLE, SI_BIT, SI_LATCH, SI_GAP} ser_st_t;

    ser_st_t          st;
    logic [NW*WW-1:0] sh;
    logic [BW-1:0]    bitc;
    logic [IW-1:0]    wleft;
    logic             ph;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= SI_IDLE; sh <= '0; bitc <= '0; wleft <= '0; ph <= 1'b0;
            sclk <= 1'b0; sdata <= 1'b0; le <= 1'b0; done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                SI_IDLE: if (start) begin
                    sh <= words; bitc <= '0; ph <= 1'b0;
                    wleft <= IW'(NW); st <= SI_BIT;
                end
                SI_BIT: begin
                    if (!ph) begin
                        sclk  <= 1'b0;
                        sdata <= sh[NW*WW-1];
                        ph    <= 1'b1;
                    end else begin
                        sclk <= 1'b1;
                        ph   <= 1'b0;
                        sh   <= sh << 1;
                        bitc <= bitc + 1'b1;
                        if (bitc == BW'(WW - 1)) st <= SI_LATCH;
                    end
                end
                SI_LATCH: begin
                    sclk  <= 1'b0;
                    le    <= 1'b1;
                    wleft <= wleft - 1'b1;
                    st    <= SI_GAP;
                end
                default: begin
                    le <= 1'b0;
                    if (wleft == '0) begin
                        done <= 1'b1;
                        st   <= SI_IDLE;
                    end else begin
                        st <= SI_BIT;
                    end
                end
            endcase
        end
    end

    p_le_with_clock_low_r1: assert property (@(posedge clk) disable iff (rst)
        le |-> !sclk);
    p_le_single_cycle_r1: assert property (@(posedge clk) disable iff (rst)
        le |=> !le);
endmodule

// File: rtl/fracn_cfg_ctrl.sv
module fracn_cfg_ctrl
    import fcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [FREQ_W-1:0] req_freq,
    output logic              busy,
    output logic              done,
    output logic [INT_W-1:0]  int_val,
    output logic [FRAC_W-1:0] frac_val,
    output logic [DSEL_W-1:0] div_sel,
    output logic [FREQ_W:0]   act_freq,
    output logic              spi_clk,
    output logic              spi_data,
    output logic              spi_le
);
    localparam logic [DIV_W-1:0] PFD_D = DIV_W'(PFD_HZ);
    localparam logic [DIV_W-1:0] MOD_D = DIV_W'(MOD_VAL);

    ctl_st_t           state;
    cfg_t              cfg;
    logic [FREQ_W-1:0] tgt, last_req;
    logic [FREQ_W:0]   act_r;
    logic              init_done;

    logic              div_start, div_done;
    logic [DIV_W-1:0]  div_a, div_b, div_q, div_r;
    logic              tx_start, tx_done;
    logic [NREG*WORD_W-1:0] tx_words;
    logic [DSEL_W-1:0] dsel_new;
    logic [FRAC_W-1:0] frac_next;
    logic              unused_bits;

    assign dsel_new    = pick_dsel(req_freq);
    assign frac_next   = div_q[FRAC_W-1:0] + 1'b1;
    assign tx_words    = build_words(init_done ? cfg : INIT_CFG);
    assign unused_bits = ^div_q[DIV_W-1:FREQ_W+1];

    fcc_seqdiv #(.W(DIV_W)) u_div (
        .clk(clk), .rst(rst), .start(div_start), .dividend(div_a),
        .divisor(div_b), .quot(div_q), .rem(div_r), .done(div_done)
    );

    fcc_serial #(.NW(NREG), .WW(WORD_W)) u_ser (
        .clk(clk), .rst(rst), .start(tx_start), .words(tx_words),
        .sclk(spi_clk), .sdata(spi_data), .le(spi_le), .done(tx_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_INIT; cfg <= '0; tgt <= '0; last_req <= '0;
            act_r <= '0; init_done <= 1'b0;
            div_start <= 1'b0; div_a <= '0; div_b <= '0; tx_start <= 1'b0;
            busy <= 1'b0; done <= 1'b0;
            int_val <= '0; frac_val <= '0; div_sel <= '0; act_freq <= '0;
        end else begin
            div_start <= 1'b0;
            tx_start  <= 1'b0;
            done      <= 1'b0;
            case (state)
                ST_INIT: begin
                    busy     <= 1'b1;
                    tx_start <= 1'b1;
                    state    <= ST_INITW;
                end
                ST_INITW: if (tx_done) begin
                    busy      <= 1'b0;
                    init_done <= 1'b1;
                    state     <= ST_IDLE;
                end
                ST_IDLE: if (req_freq != last_req) begin
                    tgt       <= req_freq;
                    last_req  <= req_freq;
                    busy      <= 1'b1;
                    cfg.dsel  <= dsel_new;
                    div_a     <= DIV_W'(req_freq) << dsel_new;
                    div_b     <= PFD_D;
                    div_start <= 1'b1;
                    state     <= ST_QINT;
                end
                ST_QINT: if (div_done) begin
                    cfg.ival  <= div_q[INT_W-1:0];
                    div_a     <= div_r * MOD_D;
                    div_start <= 1'b1;
                    state     <= ST_QFRAC;
                end
                ST_QFRAC: if (div_done) begin
                    cfg.fval  <= frac_next;
                    div_a     <= (DIV_W'(cfg.ival) * MOD_D + DIV_W'(frac_next)) * PFD_D;
                    div_b     <= MOD_D << cfg.dsel;
                    div_start <= 1'b1;
                    state     <= ST_QACT;
                end
                ST_QACT: if (div_done) begin
                    act_r    <= div_q[FREQ_W:0];
                    tx_start <= 1'b1;
                    state    <= ST_SEND;
                end
                default: if (tx_done) begin
                    int_val  <= cfg.ival;
                    frac_val <= cfg.fval;
                    div_sel  <= cfg.dsel;
                    act_freq <= act_r;
                    done     <= 1'b1;
                    busy     <= 1'b0;
                    state    <= ST_IDLE;
                end
            endcase
        end
    end

    p_done_one_cycle_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_after_busy_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));
    p_act_not_below_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> (act_freq >= {1'b0, tgt}));
    p_frac_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> (frac_val != '0));
    p_dsel_range_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> (div_sel <= DSEL_W'(DSEL_MAX)));
endmodule

// File: tb/sim_fracn_cfg_ctrl.sv
module sim_fracn_cfg_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] req = '0;
    logic        busy, done, spi_clk, spi_data, spi_le;
    logic [15:0] int_val;
    logic [11:0] frac_val;
    logic [2:0]  div_sel;
    logic [32:0] act_freq;

    fracn_cfg_ctrl u0 (
        .clk(clk), .rst(rst), .req_freq(req), .busy(busy), .done(done),
        .int_val(int_val), .frac_val(frac_val), .div_sel(div_sel),
        .act_freq(act_freq), .spi_clk(spi_clk), .spi_data(spi_data), .spi_le(spi_le)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint unsigned act, input longint unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // serial capture
    logic [31:0] sh_cap = '0;
    int          bit_cnt = 0;
    int          le_total = 0;
    logic [31:0] cap [6];

    always @(posedge spi_clk) begin
        sh_cap  = {sh_cap[30:0], spi_data};
        bit_cnt = bit_cnt + 1;
    end

    always @(posedge spi_le) begin
        chk(bit_cnt == 32, "R1", "bits per word", bit_cnt, 32);
        cap[le_total % 6] = sh_cap;
        bit_cnt  = 0;
        le_total = le_total + 1;
    end

    int busy_rises = 0;
    logic busy_q = 1'b0;
    always @(negedge clk) begin
        if (busy && !busy_q) busy_rises++;
        busy_q <= busy;
    end

    // expected-value model
    task automatic model(input longint unsigned f, output int d, output longint unsigned iv,
                         output longint unsigned fv, output longint unsigned av);
        longint unsigned n, r;
        d = 6;
        for (int k = 6; k >= 0; k--) if ((f << k) >= 64'd2200000000) d = k;
        n  = f << d;
        iv = n / 10000000;
        r  = n % 10000000;
        fv = (r * 4095) / 10000000 + 1;
        av = ((iv * 4095 + fv) * 10000000) / (64'd4095 << d);
    endtask

    task automatic check_words(input int d, input longint unsigned iv, input longint unsigned fv);
        for (int k = 0; k < 6; k++)
            chk(cap[k][2:0] == 3'(5 - k), "R1", "word address order", cap[k][2:0], 5 - k);
        chk(cap[5][30:15] == 16'(iv), "R9", "INT field", cap[5][30:15], iv);
        chk(cap[5][14:3] == 12'(fv), "R9", "FRAC field", cap[5][14:3], fv);
        chk(cap[1][22:20] == 3'(d), "R9", "divider field", cap[1][22:20], d);
        chk(cap[1][23] == 1'b1, "R9", "feedback select bit", cap[1][23], 1);
        chk(cap[4][14:3] == 12'd4095, "R2", "modulus field", cap[4][14:3], 4095);
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done);
    endtask

    task automatic expect_result(input longint unsigned f, input string tagd);
        int d; longint unsigned iv, fv, av;
        model(f, d, iv, fv, av);
        chk(busy == 1'b0, "R8", "busy falls with done", busy, 0);
        chk(int_val == 16'(iv), "R4", "int_val", int_val, iv);
        chk(frac_val == 12'(fv), "R5", "frac_val", frac_val, fv);
        chk(act_freq == 33'(av), "R6", "act_freq", act_freq, av);
        chk(act_freq >= f, "R6", "act_freq not below request", act_freq, f);
        chk(div_sel == 3'(d), tagd, "div_sel model", div_sel, d);
        check_words(d, iv, fv);
        @(negedge clk);
        chk(done == 1'b0, "R8", "done single cycle", done, 0);
    endtask

    task automatic run_cfg(input logic [31:0] f);
        int lt;
        lt = le_total;
        @(negedge clk);
        req = f;
        @(negedge clk);
        chk(busy == 1'b1, "R8", "busy after new request", busy, 1);
        wait_done();
        chk(le_total - lt == 6, "R1", "six words per update", le_total - lt, 6);
        expect_result(f, "R3");
    endtask

    localparam logic [31:0] VF [7] = '{32'd250000000, 32'd100000000, 32'd2500000000,
                                       32'd20000000, 32'd1100000000, 32'd35000000,
                                       32'd123456789};
    localparam logic [2:0]  VD [7] = '{3'd4, 3'd5, 3'd0, 3'd6, 3'd1, 3'd6, 3'd5};

    initial begin
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1", "done in reset", done, 0);
        chk(act_freq == '0, "R1", "act_freq in reset", act_freq, 0);
        chk(int_val == '0, "R1", "int_val in reset", int_val, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy == 1'b1, "R1", "busy during initialization", busy, 1);
        while (busy) @(negedge clk);
        chk(le_total == 6, "R1", "initial word count", le_total, 6);
        for (int k = 0; k < 6; k++)
            chk(cap[k][2:0] == 3'(5 - k), "R1", "initial address order", cap[k][2:0], 5 - k);
        chk(cap[5][30:15] == 16'd220, "R2", "initial INT", cap[5][30:15], 220);
        chk(cap[5][14:3] == 12'd0, "R2", "initial FRAC", cap[5][14:3], 0);
        chk(cap[1][22:20] == 3'd0, "R2", "initial divider code", cap[1][22:20], 0);
        chk(cap[4][14:3] == 12'd4095, "R2", "initial modulus", cap[4][14:3], 4095);

        for (int i = 0; i < 7; i++) begin
            run_cfg(VF[i]);
            chk(div_sel == VD[i], "R3", "div_sel table", div_sel, VD[i]);
        end

        // R7: unchanged request starts nothing
        begin
            int lt, br;
            lt = le_total; br = busy_rises;
            repeat (300) @(negedge clk);
            chk(le_total == lt, "R7", "no serial traffic on held request", le_total, lt);
            chk(busy_rises == br, "R7", "no busy on held request", busy_rises, br);
            chk(int_val == 16'd395, "R7", "int_val held", int_val, 395);
        end

        // R10: request changed mid-update
        @(negedge clk);
        req = 32'd200000000;
        repeat (20) @(negedge clk);
        chk(busy == 1'b1, "R10", "first update running", busy, 1);
        req = 32'd300000000;
        wait_done();
        expect_result(64'd200000000, "R10");
        @(negedge clk);
        chk(busy == 1'b1, "R10", "second update follows", busy, 1);
        wait_done();
        expect_result(64'd300000000, "R10");
        chk(div_sel == 3'd3, "R10", "newest request divider", div_sel, 3);

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule